// File: doc/BRIEF.md
# Shift-Register-Counted Raster Timing Generator

This block produces the horizontal sync, vertical sync, display-enable, line-start and frame-start signals for a raster display. Both axis counters are 16-bit linear feedback shift registers rather than binary counters, which keeps the next-state logic to a single XOR level. As a result every programmed threshold is an encoded count: the register state reached after the desired number of steps from the all-ones seed. Software converts plain counts to encoded values before programming them, and the block only ever compares the running state for equality.

The horizontal counter advances once per pixel enable. When it equals its end threshold, the next pixel enable reloads the seed and steps the vertical counter, which wraps at its own end threshold in the same way. Each output window is a flag that is set when its start threshold matches and cleared when its stop threshold matches. A two-state controller gates all of this. ST_IDLE holds both counters at the seed and all outputs low. The transition IDLE->RUN happens on the first clock edge with `en` high. The transition RUN->IDLE happens on any edge with `en` low.

Top module: `lfsr_vtg_top`

## Requirements
- R1: Each counter starts at 16'hFFFF. On each step it shifts left by one, and the new bit 0 is the XOR of old bits 15, 4, 2 and 1. A threshold equal to the state after k steps therefore matches at count k.
- R2: A line lasts (H+1) pixel enables, where H is the count encoded in `h_end`. The horizontal count runs 0..H and then returns to 0.
- R3: The vertical count advances by one on each horizontal wrap. A frame lasts (V+1) lines, where V is the count encoded in `v_end`.
- R4: Window rule, applied on each pixel enable in ST_RUN using the count held before that edge. If the count matches stop, the flag clears. Otherwise, if the count matches start, the flag sets. Otherwise the flag holds. Outputs therefore lag the count by one pixel enable.
- R5: `hsync` follows the window rule with `h_sync_start`/`h_sync_stop` applied to the horizontal count.
- R6: `vsync` follows the window rule with `v_sync_start`/`v_sync_stop` applied to the vertical count.
- R7: `disp_en` is high exactly when both the horizontal display window (`h_disp_start`/`h_disp_stop`) and the vertical display window (`v_disp_start`/`v_disp_stop`) are set.
- R8: `line_start` is high for one clock after each pixel-enable edge that reloads the horizontal counter.
- R9: `frame_start` is high for one clock after a pixel-enable edge that reloads both counters, and never without `line_start`.
- R10: An edge with `en` low moves to ST_IDLE, reloads both counters and drives every output low. The first edge with `en` high only enters ST_RUN and does not step the counters.
- R11: In ST_RUN, an edge with `pix_ce` low changes no counter and no output.
- R12: While `rst_n` is low, the state is ST_IDLE, both counters hold the seed and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| pix_ce | input | 1 | Pixel clock enable |
| h_disp_start | input | 16 | Encoded horizontal count where active video starts |
| h_disp_stop | input | 16 | Encoded horizontal count where active video stops |
| h_end | input | 16 | Encoded last horizontal count of a line |
| h_sync_start | input | 16 | Encoded horizontal count where hsync rises |
| h_sync_stop | input | 16 | Encoded horizontal count where hsync falls |
| v_disp_start | input | 16 | Encoded line where active video starts |
| v_disp_stop | input | 16 | Encoded line where active video stops |
| v_end | input | 16 | Encoded last line of a frame |
| v_sync_start | input | 16 | Encoded line where vsync rises |
| v_sync_stop | input | 16 | Encoded line where vsync falls |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Active display |
| line_start | output | 1 | One-clock pulse at each line wrap |
| frame_start | output | 1 | One-clock pulse at each frame wrap |

## Verification
The hardest case to reach from the ports is a pixel enable that falls on a frame wrap while `pix_ce` is sparse, or just after `en` has been dropped and raised again in mid-frame. Only there do the held flags, the one-edge entry latency of ST_RUN and the coincident reload of both counters interact. The stimulus runs small timings through several full frames. It first uses a continuous `pix_ce`, then gapped `pix_ce` patterns, and drops `en` in mid-line. It then reprograms a second geometry and repeats. Every clock is compared against an integer-count model whose thresholds are encoded by a step-by-step shift-register loop.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;
    localparam int unsigned CNT_W = 16;
    localparam logic [CNT_W-1:0] SEED = '1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vtg_state_e;

    // one step: shift left, feedback from bits 15, 4, 2, 1
    function automatic logic [CNT_W-1:0] lfsr_step(input logic [CNT_W-1:0] s);
        return {s[CNT_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction
endpackage

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter
    import lfsr_vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] end_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);
    assign at_end = (cnt == end_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= SEED;
        else if (clr)
            cnt <= SEED;
        else if (step)
            cnt <= at_end ? SEED : lfsr_step(cnt);
    end

    // R1
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);

    // R10
    clr_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == SEED);
endmodule

// File: rtl/vtg_window.sv
module vtg_window
    import lfsr_vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] stop_val,
    output logic             q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (upd) begin
            if (cnt == stop_val)
                q <= 1'b0;
            else if (cnt == start_val)
                q <= 1'b1;
        end
    end

    // R4
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(q));

    // R4
    win_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cnt == stop_val) |=> !q);
endmodule

// File: rtl/lfsr_vtg_top.sv
module lfsr_vtg_top
    import lfsr_vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pix_ce,
    input  logic [CNT_W-1:0] h_disp_start,
    input  logic [CNT_W-1:0] h_disp_stop,
    input  logic [CNT_W-1:0] h_end,
    input  logic [CNT_W-1:0] h_sync_start,
    input  logic [CNT_W-1:0] h_sync_stop,
    input  logic [CNT_W-1:0] v_disp_start,
    input  logic [CNT_W-1:0] v_disp_stop,
    input  logic [CNT_W-1:0] v_end,
    input  logic [CNT_W-1:0] v_sync_start,
    input  logic [CNT_W-1:0] v_sync_stop,
    output logic             hsync,
    output logic             vsync,
    output logic             disp_en,
    output logic             line_start,
    output logic             frame_start
);
    localparam int unsigned N_WIN = 4;
    localparam int unsigned W_HS = 0, W_HD = 1, W_VS = 2, W_VD = 3;

    vtg_state_e state_q, state_d;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic h_at_end, v_at_end;
    logic step, clr;
    logic [N_WIN-1:0] win_q;
    logic [CNT_W-1:0] win_cnt   [N_WIN];
    logic [CNT_W-1:0] win_start [N_WIN];
    logic [CNT_W-1:0] win_stop  [N_WIN];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign clr  = !en;
    assign step = (state_q == ST_RUN) && en && pix_ce;

    vtg_axis_counter u_hcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
        .end_val(h_end), .cnt(h_cnt), .at_end(h_at_end)
    );

    vtg_axis_counter u_vcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step && h_at_end),
        .end_val(v_end), .cnt(v_cnt), .at_end(v_at_end)
    );

    always_comb begin
        win_cnt[W_HS] = h_cnt; win_start[W_HS] = h_sync_start; win_stop[W_HS] = h_sync_stop;
        win_cnt[W_HD] = h_cnt; win_start[W_HD] = h_disp_start; win_stop[W_HD] = h_disp_stop;
        win_cnt[W_VS] = v_cnt; win_start[W_VS] = v_sync_start; win_stop[W_VS] = v_sync_stop;
        win_cnt[W_VD] = v_cnt; win_start[W_VD] = v_disp_start; win_stop[W_VD] = v_disp_stop;
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        vtg_window u_win (
            .clk(clk), .rst_n(rst_n), .clr(clr), .upd(step),
            .cnt(win_cnt[i]), .start_val(win_start[i]), .stop_val(win_stop[i]),
            .q(win_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_start  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            line_start  <= step && h_at_end;
            frame_start <= step && h_at_end && v_at_end;
        end
    end

    assign hsync   = win_q[W_HS];
    assign vsync   = win_q[W_VS];
    assign disp_en = win_q[W_HD] && win_q[W_VD];

    // R10
    en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hsync && !vsync && !disp_en && !line_start && !frame_start));

    // R11
    ce_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && !pix_ce) |=>
            ($stable(hsync) && $stable(vsync) && $stable(disp_en)));

    // R9
    frame_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);

    // R8
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> $past(pix_ce) && $past(en));
endmodule

// File: tb/lfsr_vtg_top_tb.sv
module lfsr_vtg_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic pix_ce = 1'b0;
    logic [15:0] h_ds, h_de, h_e, h_ss, h_se, v_ds, v_de, v_e, v_ss, v_se;
    logic hsync, vsync, disp_en, line_start, frame_start;

    always #2 clk = ~clk;

    lfsr_vtg_top u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pix_ce(pix_ce),
        .h_disp_start(h_ds), .h_disp_stop(h_de), .h_end(h_e),
        .h_sync_start(h_ss), .h_sync_stop(h_se),
        .v_disp_start(v_ds), .v_disp_stop(v_de), .v_end(v_e),
        .v_sync_start(v_ss), .v_sync_stop(v_se),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .line_start(line_start), .frame_start(frame_start)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // integer geometry
    int HEND, HSS, HSE, HDS, HDE, VEND, VSS, VSE, VDS, VDE;
    // model state
    int h, v;
    bit run, m_hs, m_vs, m_hd, m_vd, m_ls, m_fs;

    // R1: encoded count = state after k steps from all-ones
    function automatic logic [15:0] enc(int k);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < k; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    function automatic bit win(bit q, int k, int s, int e);
        if (k == e) return 1'b0;
        if (k == s) return 1'b1;
        return q;
    endfunction

    task automatic program_geom();
        h_e = enc(HEND); h_ss = enc(HSS); h_se = enc(HSE); h_ds = enc(HDS); h_de = enc(HDE);
        v_e = enc(VEND); v_ss = enc(VSS); v_se = enc(VSE); v_ds = enc(VDS); v_de = enc(VDE);
    endtask

    task automatic chk(string req, string nm, bit act, bit exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (h=%0d v=%0d t=%0t)",
                     req, nm, act, exp, h, v, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5", "hsync", hsync, m_hs);
        chk("R6", "vsync", vsync, m_vs);
        chk("R7", "disp_en", disp_en, m_hd & m_vd);
        chk("R8", "line_start", line_start, m_ls);
        chk("R9", "frame_start", frame_start, m_fs);
    endtask

    // one clock: apply inputs, model the edge, compare after it
    task automatic tick(bit e, bit ce);
        en = e; pix_ce = ce;
        @(posedge clk); #1;
        m_ls = 0; m_fs = 0;
        if (!e) begin                       // R10
            run = 0; h = 0; v = 0;
            m_hs = 0; m_vs = 0; m_hd = 0; m_vd = 0;
        end else if (!run) begin            // R10 entry edge, no step
            run = 1;
        end else if (ce) begin              // R4 R11
            m_hs = win(m_hs, h, HSS, HSE);
            m_hd = win(m_hd, h, HDS, HDE);
            m_vs = win(m_vs, v, VSS, VSE);
            m_vd = win(m_vd, v, VDS, VDE);
            if (h == HEND) begin            // R2 R3
                m_ls = 1; h = 0;
                if (v == VEND) begin m_fs = 1; v = 0; end
                else v++;
            end else h++;
        end
        compare_all();
    endtask

    initial begin
        HEND = 9; HSS = 1; HSE = 3; HDS = 4; HDE = 8;
        VEND = 6; VSS = 0; VSE = 2; VDS = 3; VDE = 5;
        program_geom();
        h = 0; v = 0; run = 0;
        m_hs = 0; m_vs = 0; m_hd = 0; m_vd = 0; m_ls = 0; m_fs = 0;
        // R12: reset state
        repeat (3) begin @(posedge clk); #1; compare_all(); end
        rst_n = 1'b1;
        // R1 R2 R3: continuous pixel enable over three frames
        for (int i = 0; i < 215; i++) tick(1, 1);
        // R11: gapped pixel enable
        for (int i = 0; i < 160; i++) tick(1, (i % 2) == 1);
        // R10: drop enable mid-line, then restart
        for (int i = 0; i < 3; i++) tick(0, 1);
        for (int i = 0; i < 150; i++) tick(1, (i % 5) != 2);
        // second geometry, programmed while disabled
        tick(0, 0);
        HEND = 12; HSS = 1; HSE = 5; HDS = 6; HDE = 11;
        VEND = 4; VSS = 0; VSE = 1; VDS = 2; VDE = 4;
        program_geom();
        tick(0, 0);
        for (int i = 0; i < 200; i++) tick(1, (i % 3) != 0);
        for (int i = 0; i < 70; i++) tick(1, 1);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule